// File: doc/BRIEF.md
# USB Device Event and Interrupt Register File

This block gathers the single-cycle event strobes produced by a USB device protocol engine and holds them in byte-wide registers that a CPU can read and clear. It has three flag registers: one for general bus events (setup data, start of frame, setup token, suspend, bus reset, high-speed entry), one for IN endpoint completions and one for OUT endpoint completions. Each flag register has its own enable register, and a single interrupt line rises whenever an enabled flag is pending.

A read-only vector register reports which class of event has priority, as a fixed and non-contiguous code. An interrupt handler can use that code as a jump offset and skip decoding a bitmask. A small endpoint-0 control/status register holds a software stall bit, a NAK flag that the core raises and software clears, and the live busy state of endpoint 0 in each direction. Flags are cleared by writing a 1 to the bit. The CPU port is a plain 3-bit address, byte-wide bus with a registered read path.

Top module: `usb_evt_regs`

## Requirements
- R1: After reset, every flag, enable and the stall bit are 0, `irq` is low, `bus_rdata` is 0x00, and the vector register (address 6) reads 0xFF.
- R2: The general flag register (address 0) sets bit 0 on setup data, bit 1 on start of frame, bit 2 on setup token, bit 3 on suspend, bit 4 on bus reset and bit 5 on high-speed entry, one bit for each strobe on `gen_evt` in that order. A set bit holds until it is cleared, and bits 7:6 read 0.
- R3: A write to a flag register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event strobe and a write-1 clear of the same bit happen in the same cycle, the flag is set after that edge.
- R5: The IN endpoint flag register (address 2) and the OUT endpoint flag register (address 4) hold endpoint n in bit n for endpoints 0 to 2. They are set by `ep_in_evt` and `ep_out_evt`, and their upper bits read 0.
- R6: The enable registers can be read and written: general at address 1 (bits 5:0, same layout as address 0), IN at address 3 and OUT at address 5 (bits 2:0). Unused bits read 0.
- R7: `irq` is high exactly when some flag bit and its matching enable bit are both 1, in any of the three pairs. It follows the register state in the same cycle.
- R8: The vector register reads 0x10 when an enabled bus reset is pending. Otherwise it reads 0x14 for an enabled high-speed entry, then 0x00 for enabled setup data, then 0x28 for any enabled endpoint flag, and otherwise 0xFF. Start of frame, setup token and suspend are not vectored.
- R9: The endpoint-0 register (address 7) holds the stall bit in bit 0, which software writes. Bit 1 is the NAK flag, set by `ep0_nak_evt` and cleared by writing 1; the strobe wins over a clear in the same cycle. Bits 2 and 3 show `ep0_in_busy` and `ep0_out_busy`. NAK never drives `irq`.
- R10: `bus_rdata` loads the addressed register on a clock edge where `bus_rd` is high, and holds its value at every other edge.
- R11: Writes to the vector register change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_evt | input | 6 | General event strobes, one cycle each, in flag bit order |
| ep_in_evt | input | NUM_EP | IN endpoint completion strobes |
| ep_out_evt | input | NUM_EP | OUT endpoint completion strobes |
| ep0_nak_evt | input | 1 | Endpoint-0 NAK strobe |
| ep0_in_busy | input | 1 | Endpoint-0 IN busy level |
| ep0_out_busy | input | 1 | Endpoint-0 OUT busy level |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a strobe and a write-1 clear hitting the same bit on the same edge. The stimulus drives `gen_evt` or `ep0_nak_evt` together with a clearing write in one cycle, then reads the register back. The vector priority ladder is also hard to reach, because it needs several classes pending at once. The bench raises four classes with one strobe vector and then clears them one by one, reading the vector after each step. A separate step masks the top-priority class through its enable to show that the vector skips it.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int GEN_W  = 6;

    typedef enum logic [ADDR_W-1:0] {
        SEL_GEN_FLAG = 3'd0,
        SEL_GEN_EN   = 3'd1,
        SEL_IN_FLAG  = 3'd2,
        SEL_IN_EN    = 3'd3,
        SEL_OUT_FLAG = 3'd4,
        SEL_OUT_EN   = 3'd5,
        SEL_VECTOR   = 3'd6,
        SEL_EP0      = 3'd7
    } reg_sel_e;

    // general event bit positions
    localparam int GEV_SETUP_DATA = 0;
    localparam int GEV_SOF        = 1;
    localparam int GEV_SETUP_TOK  = 2;
    localparam int GEV_SUSPEND    = 3;
    localparam int GEV_BUS_RESET  = 4;
    localparam int GEV_HS_ENTER   = 5;

    // endpoint-0 control/status bit positions
    localparam int EP0_STALL    = 0;
    localparam int EP0_NAK      = 1;
    localparam int EP0_IN_BUSY  = 2;
    localparam int EP0_OUT_BUSY = 3;

    // vector codes
    localparam logic [DATA_W-1:0] VEC_SETUP     = 8'h00;
    localparam logic [DATA_W-1:0] VEC_BUS_RESET = 8'h10;
    localparam logic [DATA_W-1:0] VEC_HS_ENTER  = 8'h14;
    localparam logic [DATA_W-1:0] VEC_ENDPOINT  = 8'h28;
    localparam logic [DATA_W-1:0] VEC_NONE      = 8'hFF;

endpackage

// File: rtl/usb_w1c_bank.sv
// Bank of sticky flags: set by strobes, cleared by writing 1, set wins.
module usb_w1c_bank #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         wr_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] clr_mask;

    assign clr_mask = wr_i ? clr_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else begin
            q_o <= (q_o & ~clr_mask) | set_i;
        end
    end

endmodule

// File: rtl/usb_rw_reg.sv
// Plain software-written register.
module usb_rw_reg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (wr_i) begin
            q_o <= wdata_i;
        end
    end

endmodule

// File: rtl/usb_vec_encoder.sv
// Fixed-priority encoder from enabled pending events to a jump code.
module usb_vec_encoder
    import usb_irq_pkg::*;
(
    input  logic [GEN_W-1:0]  gen_act_i,
    input  logic              ep_act_i,
    output logic [DATA_W-1:0] code_o
);

    always_comb begin
        if (gen_act_i[GEV_BUS_RESET]) begin
            code_o = VEC_BUS_RESET;
        end else if (gen_act_i[GEV_HS_ENTER]) begin
            code_o = VEC_HS_ENTER;
        end else if (gen_act_i[GEV_SETUP_DATA]) begin
            code_o = VEC_SETUP;
        end else if (ep_act_i) begin
            code_o = VEC_ENDPOINT;
        end else begin
            code_o = VEC_NONE;
        end
    end

endmodule

// File: rtl/usb_evt_regs.sv
module usb_evt_regs
    import usb_irq_pkg::*;
#(
    parameter int NUM_EP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GEN_W-1:0]  gen_evt,
    input  logic [NUM_EP-1:0] ep_in_evt,
    input  logic [NUM_EP-1:0] ep_out_evt,
    input  logic              ep0_nak_evt,
    input  logic              ep0_in_busy,
    input  logic              ep0_out_busy,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    localparam int N_DIR = 2;

    reg_sel_e          sel;
    logic [GEN_W-1:0]  gen_flag_q;
    logic [GEN_W-1:0]  gen_en_q;
    logic [NUM_EP-1:0] ep_flag_q [N_DIR];
    logic [NUM_EP-1:0] ep_en_q   [N_DIR];
    logic [NUM_EP-1:0] ep_act_v  [N_DIR];
    logic              stall_q;
    logic              nak_q;
    logic [GEN_W-1:0]  gen_act;
    logic              ep_act;
    logic [DATA_W-1:0] vec_code;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata_hi;

    assign sel             = reg_sel_e'(bus_addr);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:GEN_W];

    // general event flags and enables
    usb_w1c_bank #(.W(GEN_W)) u_gen_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (gen_evt),
        .wr_i  (bus_wr && (sel == SEL_GEN_FLAG)),
        .clr_i (bus_wdata[GEN_W-1:0]),
        .q_o   (gen_flag_q)
    );

    usb_rw_reg #(.W(GEN_W)) u_gen_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr && (sel == SEL_GEN_EN)),
        .wdata_i (bus_wdata[GEN_W-1:0]),
        .q_o     (gen_en_q)
    );

    // per-direction endpoint flags and enables (0 = IN, 1 = OUT)
    for (genvar d = 0; d < N_DIR; d++) begin : g_ep_dir
        localparam reg_sel_e FLG_SEL = (d == 0) ? SEL_IN_FLAG : SEL_OUT_FLAG;
        localparam reg_sel_e EN_SEL  = (d == 0) ? SEL_IN_EN   : SEL_OUT_EN;

        logic [NUM_EP-1:0] set_v;

        assign set_v = (d == 0) ? ep_in_evt : ep_out_evt;

        usb_w1c_bank #(.W(NUM_EP)) u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v),
            .wr_i  (bus_wr && (sel == FLG_SEL)),
            .clr_i (bus_wdata[NUM_EP-1:0]),
            .q_o   (ep_flag_q[d])
        );

        usb_rw_reg #(.W(NUM_EP)) u_en (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (bus_wr && (sel == EN_SEL)),
            .wdata_i (bus_wdata[NUM_EP-1:0]),
            .q_o     (ep_en_q[d])
        );

        assign ep_act_v[d] = ep_flag_q[d] & ep_en_q[d];
    end

    // endpoint-0 control/status
    usb_rw_reg #(.W(1)) u_stall (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr && (sel == SEL_EP0)),
        .wdata_i (bus_wdata[EP0_STALL]),
        .q_o     (stall_q)
    );

    usb_w1c_bank #(.W(1)) u_nak (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ep0_nak_evt),
        .wr_i  (bus_wr && (sel == SEL_EP0)),
        .clr_i (bus_wdata[EP0_NAK]),
        .q_o   (nak_q)
    );

    // interrupt and vector
    assign gen_act = gen_flag_q & gen_en_q;
    assign ep_act  = |(ep_act_v[0] | ep_act_v[1]);
    assign irq     = (|gen_act) | ep_act;

    usb_vec_encoder u_vec (
        .gen_act_i (gen_act),
        .ep_act_i  (ep_act),
        .code_o    (vec_code)
    );

    // read path
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_GEN_FLAG: rd_mux[GEN_W-1:0]  = gen_flag_q;
            SEL_GEN_EN:   rd_mux[GEN_W-1:0]  = gen_en_q;
            SEL_IN_FLAG:  rd_mux[NUM_EP-1:0] = ep_flag_q[0];
            SEL_IN_EN:    rd_mux[NUM_EP-1:0] = ep_en_q[0];
            SEL_OUT_FLAG: rd_mux[NUM_EP-1:0] = ep_flag_q[1];
            SEL_OUT_EN:   rd_mux[NUM_EP-1:0] = ep_en_q[1];
            SEL_VECTOR:   rd_mux             = vec_code;
            SEL_EP0: begin
                rd_mux[EP0_STALL]    = stall_q;
                rd_mux[EP0_NAK]      = nak_q;
                rd_mux[EP0_IN_BUSY]  = ep0_in_busy;
                rd_mux[EP0_OUT_BUSY] = ep0_out_busy;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/usb_evt_regs_chk.sv
module usb_evt_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] gen_evt,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic       irq,
    input logic [5:0] gen_flag,
    input logic [5:0] gen_en,
    input logic [7:0] vec
);

    // R2: general flags hold without strobe or write
    assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && gen_evt == 6'd0) |=> $stable(gen_flag));

    // R3: clearing write without strobe leaves written bits at 0
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && gen_evt == 6'd0)
        |=> ((gen_flag & $past(bus_wdata[5:0])) == 6'd0));

    // R4: a strobe always leaves its bit set
    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_evt != 6'd0) |=> ((gen_flag & $past(gen_evt)) == $past(gen_evt)));

    // R7: an enabled pending general flag raises irq
    assert_irq_gen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gen_flag & gen_en) != 6'd0) |-> irq);

    // R8: with no interrupt the vector is idle
    assert_vec_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (vec == 8'hFF));

    // R10: read data holds without a read strobe
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind usb_evt_regs usb_evt_regs_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_evt   (gen_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .gen_flag  (gen_flag_q),
    .gen_en    (gen_en_q),
    .vec       (vec_code)
);

// File: tb/tb_usb_evt_regs.sv
`timescale 1ns/1ps
module tb_usb_evt_regs;

    localparam int NUM_EP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [5:0]        gen_evt = '0;
    logic [NUM_EP-1:0] ep_in_evt = '0;
    logic [NUM_EP-1:0] ep_out_evt = '0;
    logic              ep0_nak_evt = 1'b0;
    logic              ep0_in_busy = 1'b0;
    logic              ep0_out_busy = 1'b0;
    logic [2:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_rdata;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    usb_evt_regs #(.NUM_EP(NUM_EP)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .gen_evt      (gen_evt),
        .ep_in_evt    (ep_in_evt),
        .ep_out_evt   (ep_out_evt),
        .ep0_nak_evt  (ep0_nak_evt),
        .ep0_in_busy  (ep0_in_busy),
        .ep0_out_busy (ep0_out_busy),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .irq          (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_gf, m_ge, m_if, m_ie, m_of, m_oe, m_st, m_nak, m_rd;

    function automatic int m_vec();
        int ga = m_gf & m_ge;
        int ea = (m_if & m_ie) | (m_of & m_oe);
        if ((ga / 16) % 2 == 1) return 'h10;
        if ((ga / 32) % 2 == 1) return 'h14;
        if (ga % 2 == 1)        return 'h00;
        if (ea != 0)            return 'h28;
        return 'hFF;
    endfunction

    function automatic int m_irq();
        return (((m_gf & m_ge) | (m_if & m_ie) | (m_of & m_oe)) != 0) ? 1 : 0;
    endfunction

    function automatic int m_read(input int a);
        case (a)
            0: return m_gf;
            1: return m_ge;
            2: return m_if;
            3: return m_ie;
            4: return m_of;
            5: return m_oe;
            6: return m_vec();
            default: return m_st + 2 * m_nak + 4 * int'(ep0_in_busy) + 8 * int'(ep0_out_busy);
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gf = 0; m_ge = 0; m_if = 0; m_ie = 0; m_of = 0; m_oe = 0;
            m_st = 0; m_nak = 0; m_rd = 0;
        end else begin
            if (bus_rd) m_rd = m_read(int'(bus_addr));
            if (bus_wr) begin
                case (int'(bus_addr))
                    0: m_gf = m_gf & ~int'(bus_wdata[5:0]);
                    1: m_ge = int'(bus_wdata[5:0]);
                    2: m_if = m_if & ~int'(bus_wdata[2:0]);
                    3: m_ie = int'(bus_wdata[2:0]);
                    4: m_of = m_of & ~int'(bus_wdata[2:0]);
                    5: m_oe = int'(bus_wdata[2:0]);
                    7: begin
                        m_st = int'(bus_wdata[0]);
                        if (bus_wdata[1]) m_nak = 0;
                    end
                    default: ;
                endcase
            end
            m_gf = m_gf | int'(gen_evt);
            m_if = m_if | int'(ep_in_evt);
            m_of = m_of | int'(ep_out_evt);
            if (ep0_nak_evt) m_nak = 1;
        end
    end

    // per-cycle comparison against the model (R7, R10)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 model read data", bus_rdata, 8'(m_rd));
            check("R7 model irq", {7'd0, irq}, 8'(m_irq()));
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        #1 check(tag, bus_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic gp(input logic [5:0] g);
        @(negedge clk);
        gen_evt = g;
        @(negedge clk);
        gen_evt = '0;
    endtask

    task automatic irq_is(input logic exp, input string tag);
        @(negedge clk);
        #1 check(tag, {7'd0, irq}, {7'd0, exp});
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1 rdata after reset", bus_rdata, 8'h00);
        check("R1 irq after reset", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 6; a++) rd(3'(a), 8'h00, "R1 register zero");
        rd(3'd6, 8'hFF, "R1 vector idle");
        rd(3'd7, 8'h00, "R1 ep0 zero");

        // R2: each general strobe at its own bit
        gp(6'h01); rd(3'd0, 8'h01, "R2 setup data bit0");
        gp(6'h02); rd(3'd0, 8'h03, "R2 sof bit1");
        gp(6'h04); gp(6'h08); gp(6'h10);
        rd(3'd0, 8'h1F, "R2 token suspend reset bits");
        gp(6'h20); rd(3'd0, 8'h3F, "R2 hs bit5");

        // R3: write-1 clear
        wr(3'd0, 8'h00); rd(3'd0, 8'h3F, "R3 write zero keeps");
        wr(3'd0, 8'h05); rd(3'd0, 8'h3A, "R3 partial clear");
        wr(3'd0, 8'hFF); rd(3'd0, 8'h00, "R3 full clear");

        // R4: set wins over same-cycle clear
        gp(6'h02);
        @(negedge clk);
        gen_evt = 6'h02; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hFF;
        @(negedge clk);
        gen_evt = '0; bus_wr = 1'b0; bus_wdata = '0;
        rd(3'd0, 8'h02, "R4 strobe beats clear");
        wr(3'd0, 8'h02); rd(3'd0, 8'h00, "R3 cleared after race");

        // R5: endpoint flags
        @(negedge clk);
        ep_in_evt = 3'b101; ep_out_evt = 3'b010;
        @(negedge clk);
        ep_in_evt = '0; ep_out_evt = '0;
        rd(3'd2, 8'h05, "R5 in flags");
        rd(3'd4, 8'h02, "R5 out flags");
        wr(3'd2, 8'hFF); rd(3'd2, 8'h00, "R5 in cleared");

        // R6: enables
        wr(3'd1, 8'hFF); rd(3'd1, 8'h3F, "R6 gen enable width");
        wr(3'd3, 8'hFF); rd(3'd3, 8'h07, "R6 in enable width");
        wr(3'd5, 8'h02); rd(3'd5, 8'h02, "R6 out enable");

        // R7/R8: endpoint interrupt
        irq_is(1'b1, "R7 out ep1 irq");
        rd(3'd6, 8'h28, "R8 endpoint vector");
        wr(3'd4, 8'h02);
        irq_is(1'b0, "R7 irq drops");
        rd(3'd6, 8'hFF, "R8 vector idle");

        // R8: unvectored event
        wr(3'd1, 8'h02); wr(3'd3, 8'h00); wr(3'd5, 8'h00);
        gp(6'h02);
        irq_is(1'b1, "R7 sof irq");
        rd(3'd6, 8'hFF, "R8 sof not vectored");

        // R8: priority ladder
        wr(3'd1, 8'h3F); wr(3'd3, 8'h07);
        @(negedge clk);
        gen_evt = 6'h33; ep_in_evt = 3'b001;
        @(negedge clk);
        gen_evt = '0; ep_in_evt = '0;
        rd(3'd6, 8'h10, "R8 bus reset first");
        wr(3'd0, 8'h10); rd(3'd6, 8'h14, "R8 hs second");
        wr(3'd0, 8'h20); rd(3'd6, 8'h00, "R8 setup third");
        wr(3'd0, 8'h01); rd(3'd6, 8'h28, "R8 endpoint fourth");
        wr(3'd2, 8'h01); rd(3'd6, 8'hFF, "R8 sof left unvectored");
        irq_is(1'b1, "R7 sof still pending");
        wr(3'd0, 8'h02);
        irq_is(1'b0, "R7 all clear");

        // R8: disabled reset skipped
        wr(3'd1, 8'h21);
        gp(6'h11);
        rd(3'd6, 8'h00, "R8 masked reset skipped");
        wr(3'd0, 8'hFF);

        // R9: endpoint 0 register
        wr(3'd7, 8'h01); rd(3'd7, 8'h01, "R9 stall set");
        @(negedge clk); ep0_nak_evt = 1'b1;
        @(negedge clk); ep0_nak_evt = 1'b0;
        rd(3'd7, 8'h03, "R9 nak set");
        irq_is(1'b0, "R9 nak no irq");
        ep0_in_busy = 1'b1;
        rd(3'd7, 8'h07, "R9 in busy");
        ep0_out_busy = 1'b1;
        rd(3'd7, 8'h0F, "R9 out busy");
        ep0_in_busy = 1'b0; ep0_out_busy = 1'b0;
        wr(3'd7, 8'h03); rd(3'd7, 8'h01, "R9 nak cleared stall kept");
        wr(3'd7, 8'h00); rd(3'd7, 8'h00, "R9 stall cleared");
        @(negedge clk);
        ep0_nak_evt = 1'b1; bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 8'h02;
        @(negedge clk);
        ep0_nak_evt = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(3'd7, 8'h02, "R9 nak strobe beats clear");
        wr(3'd7, 8'h02); rd(3'd7, 8'h00, "R9 nak cleared");

        // R11: vector writes ignored
        wr(3'd1, 8'h3F);
        gp(6'h10);
        rd(3'd6, 8'h10, "R11 vector before write");
        wr(3'd6, 8'h00);
        rd(3'd6, 8'h10, "R11 vector unchanged");
        rd(3'd0, 8'h10, "R11 flags unchanged");
        rd(3'd1, 8'h3F, "R11 enables unchanged");

        // R10: hold without read
        repeat (3) @(negedge clk);
        #1 check("R10 rdata held", bus_rdata, 8'h3F);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule